// File: doc/BRIEF.md
# Binary Reference Correlator Lane

This block computes a single lag of a cross-correlation. It takes a row of narrow data samples and a row of one-bit reference chips. Each chip weights its paired sample by +1 or -1. Because of that, the per-lane multiply reduces to a choice between the sample and its negation. All lanes are evaluated in parallel within one clock. A balanced adder tree collects the weighted terms, and the total is captured in a register wide enough to hold every possible result.

Samples arrive in offset-binary (excess) coding. Before weighting, each lane turns its sample into a signed value by flipping the top bit. The surrounding logic presents a full window of samples and chips together with a valid strobe. One cycle later it receives the correlation value with a matching valid flag. Between strobes the output register keeps the last result.

Top module: `corr_lane`

## Requirements
- R1: Sample k occupies bits k*SAMPLE_W to k*SAMPLE_W+SAMPLE_W-1 of `data_flat` and is weighted only by `ref_bits[k]`.
- R2: A chip value of 1 adds the sample's signed value to the sum unchanged.
- R3: A chip value of 0 adds zero minus the sample's signed value, so code 0x00 contributes +128.
- R4: A sample code c has signed value c - 2^(SAMPLE_W-1): 0x80 is zero, 0x00 is -128 and 0xFF is +127.
- R5: `corr_sum` is a two's-complement value SAMPLE_W + ceil(log2 LANES) + 1 bits wide (12 bits by default). It never wraps, including at the extremes +LANES*128 and -LANES*128.
- R6: `out_valid` is high exactly one cycle after a cycle with `in_valid` high, and `corr_sum` then holds the sum of that cycle's inputs. Back-to-back strobes give back-to-back results.
- R7: While `in_valid` is low, `corr_sum` holds its previous value and any change on `data_flat` or `ref_bits` has no effect on it.
- R8: Synchronous reset `rst` clears `corr_sum` to zero and `out_valid` to low at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Marks a window of samples and chips to correlate |
| data_flat | input | LANES*SAMPLE_W | Offset-binary samples, lane k in slice k |
| ref_bits | input | LANES | Reference chips, 1 means +1 and 0 means -1 |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| corr_sum | output | SAMPLE_W+clog2(LANES)+1 | Registered signed correlation value |

## Verification
The hardest outputs to reach are the two extremes of the sum. The positive extreme needs every lane at code 0x00 with every chip at 0, so that each negation produces +128. Random stimulus almost never lines up all eight lanes like that, so directed windows drive both extremes and the ±127 cases. Lane-isolation windows set a single lane away from 0x80 to pin down the bit slice each chip pairs with. Idle cycles that carry changing data test the hold behaviour.

// File: rtl/corr_pkg.sv
package corr_pkg;

  // Width needed for a signed sum of `lanes` terms, each one bit wider than a sample
  function automatic int corr_sum_width(input int lanes, input int sample_w);
    return sample_w + $clog2(lanes) + 1;
  endfunction

  // Largest magnitude that a single weighted term can reach
  function automatic int corr_term_peak(input int sample_w);
    return 1 << (sample_w - 1);
  endfunction

endpackage

// File: rtl/corr_sign_lane.sv
module corr_sign_lane #(
  parameter int SAMPLE_W = 8,
  localparam int TERM_W  = SAMPLE_W + 1
) (
  input  logic [SAMPLE_W-1:0]      code,
  input  logic                     ref_bit,
  output logic signed [TERM_W-1:0] term
);

  // offset-binary -> two's complement: flip the MSB, then sign-extend by one bit
  function automatic logic signed [TERM_W-1:0] excess_to_signed(input logic [SAMPLE_W-1:0] c);
    logic [SAMPLE_W-1:0] t;
    t = c;
    t[SAMPLE_W-1] = ~c[SAMPLE_W-1];
    return {t[SAMPLE_W-1], t};
  endfunction

  // +1 / -1 weighting; the extra bit keeps -(-2^(W-1)) representable
  function automatic logic signed [TERM_W-1:0] weight(input logic signed [TERM_W-1:0] v,
                                                      input logic r);
    return r ? v : -v;
  endfunction

  logic signed [TERM_W-1:0] signed_sample;

  assign signed_sample = excess_to_signed(code);
  assign term          = weight(signed_sample, ref_bit);

endmodule

// File: rtl/corr_adder_tree.sv
module corr_adder_tree #(
  parameter int LEAVES = 8,
  parameter int IN_W   = 9,
  parameter int OUT_W  = 12,
  localparam int DEPTH = $clog2(LEAVES),
  localparam int SLOTS = 1 << DEPTH
) (
  input  logic [LEAVES*IN_W-1:0]  terms_flat,
  output logic signed [OUT_W-1:0] total
);

  // heap layout: node 1 is the root, nodes SLOTS..2*SLOTS-1 are the leaves
  logic signed [OUT_W-1:0] node [1:2*SLOTS-1];

  for (genvar j = 0; j < SLOTS; j++) begin : g_leaf
    if (j < LEAVES) begin : g_used
      assign node[SLOTS+j] = OUT_W'($signed(terms_flat[j*IN_W +: IN_W]));
    end else begin : g_pad
      assign node[SLOTS+j] = '0;
    end
  end

  for (genvar i = 1; i < SLOTS; i++) begin : g_sum
    assign node[i] = node[2*i] + node[2*i+1];
  end

  assign total = node[1];

endmodule

// File: rtl/corr_lane.sv
module corr_lane #(
  parameter int LANES    = 8,
  parameter int SAMPLE_W = 8,
  localparam int SUM_W   = corr_pkg::corr_sum_width(LANES, SAMPLE_W),
  localparam int TERM_W  = SAMPLE_W + 1
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      in_valid,
  input  logic [LANES*SAMPLE_W-1:0] data_flat,
  input  logic [LANES-1:0]          ref_bits,
  output logic                      out_valid,
  output logic [SUM_W-1:0]          corr_sum
);

  logic [LANES*TERM_W-1:0] terms_flat;
  logic signed [SUM_W-1:0] tree_sum;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    corr_sign_lane #(.SAMPLE_W(SAMPLE_W)) u_lane (
      .code    (data_flat[k*SAMPLE_W +: SAMPLE_W]),
      .ref_bit (ref_bits[k]),
      .term    (terms_flat[k*TERM_W +: TERM_W])
    );
  end

  corr_adder_tree #(.LEAVES(LANES), .IN_W(TERM_W), .OUT_W(SUM_W)) u_tree (
    .terms_flat (terms_flat),
    .total      (tree_sum)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      corr_sum  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) corr_sum <= tree_sum;
    end
  end

endmodule

// File: rtl/corr_lane_chk.sv
module corr_lane_chk #(
  parameter int LANES    = 8,
  parameter int SAMPLE_W = 8,
  parameter int SUM_W    = 12
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     in_valid,
  input logic signed [SUM_W-1:0]  tree_sum,
  input logic                     out_valid,
  input logic [SUM_W-1:0]         corr_sum
);

  localparam int LIMIT = LANES * corr_pkg::corr_term_peak(SAMPLE_W);

  p_result_latency_r6: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (out_valid && corr_sum == $past(tree_sum)));

  p_no_spurious_valid_r6: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  p_hold_when_idle_r7: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(corr_sum));

  p_no_overflow_r5: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (int'($signed(corr_sum)) <= LIMIT && int'($signed(corr_sum)) >= -LIMIT));

  p_reset_clears_r8: assert property (@(posedge clk)
    rst |=> (corr_sum == '0 && !out_valid));

endmodule

bind corr_lane corr_lane_chk #(.LANES(LANES), .SAMPLE_W(SAMPLE_W), .SUM_W(SUM_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .tree_sum  (tree_sum),
  .out_valid (out_valid),
  .corr_sum  (corr_sum)
);

// File: tb/corr_lane_tb.sv
module corr_lane_tb;

  localparam int N  = 8;
  localparam int SW = 8;
  localparam int OW = SW + $clog2(N) + 1;

  logic          clk = 1'b0;
  logic          rst;
  logic          in_valid;
  logic [N*SW-1:0] data_flat;
  logic [N-1:0]  ref_bits;
  logic          out_valid;
  logic [OW-1:0] corr_sum;

  int checks = 0;
  int fails  = 0;
  int seed_sink;

  always #4 clk = ~clk;

  corr_lane #(.LANES(N), .SAMPLE_W(SW)) u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .data_flat(data_flat),
    .ref_bits(ref_bits), .out_valid(out_valid), .corr_sum(corr_sum)
  );

  // reference model: value = code - 128, weight +1 for chip 1, -1 for chip 0
  function automatic int model(input logic [N*SW-1:0] d, input logic [N-1:0] r);
    int acc = 0;
    for (int k = 0; k < N; k++) begin
      int v = int'(d[k*SW +: SW]) - 128;
      acc += r[k] ? v : -v;
    end
    return acc;
  endfunction

  function automatic logic [N*SW-1:0] fill(input logic [SW-1:0] c);
    logic [N*SW-1:0] d;
    for (int k = 0; k < N; k++) d[k*SW +: SW] = c;
    return d;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic apply(input string tag, input logic [N*SW-1:0] d, input logic [N-1:0] r);
    @(negedge clk);
    in_valid = 1'b1; data_flat = d; ref_bits = r;
    @(posedge clk); #1;
    check({tag, " R6 valid"}, int'(out_valid), 1);
    check(tag, int'($signed(corr_sum)), model(d, r));
  endtask

  task automatic idle;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [N*SW-1:0] d;
    logic [N-1:0] r;
    int held;
    seed_sink = $urandom(32'h5eed_1234);
    rst = 1'b1; in_valid = 1'b0; data_flat = '0; ref_bits = '0;
    repeat (3) @(posedge clk); #1;
    check("R8 reset sum", int'($signed(corr_sum)), 0);
    check("R8 reset valid", int'(out_valid), 0);
    @(negedge clk); rst = 1'b0;

    // R4 midpoint code is zero
    apply("R4 all 0x80", fill(8'h80), '1);
    // R5 extremes
    apply("R5 R3 +max", fill(8'h00), '0);
    check("R5 +1024", int'($signed(corr_sum)), 1024);
    apply("R5 R2 -max", fill(8'h00), '1);
    check("R5 -1024", int'($signed(corr_sum)), -1024);
    apply("R4 R2 0xFF", fill(8'hFF), '1);
    check("R4 +1016", int'($signed(corr_sum)), 1016);
    apply("R4 R3 0xFF", fill(8'hFF), '0);
    check("R3 -1016", int'($signed(corr_sum)), -1016);

    // R1 lane isolation
    for (int k = 0; k < N; k++) begin
      d = fill(8'h80);
      d[k*SW +: SW] = 8'(8'h80 + k + 1);
      r = '1;
      apply("R1 R2 lane", d, r);
      check("R1 lane pos", int'($signed(corr_sum)), k + 1);
      r[k] = 1'b0;
      apply("R1 R3 lane", d, r);
      check("R1 lane neg", int'($signed(corr_sum)), -(k + 1));
    end

    // R7 hold while idle with changing inputs
    apply("R7 load", fill(8'h90), 8'hA5);
    held = model(fill(8'h90), 8'hA5);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      in_valid = 1'b0; data_flat = {$urandom, $urandom}; ref_bits = 8'($urandom);
      @(posedge clk); #1;
      check("R7 hold", int'($signed(corr_sum)), held);
      check("R6 idle valid", int'(out_valid), 0);
    end

    // R6 back-to-back random stream with R2/R3 mix
    for (int i = 0; i < 300; i++) begin
      d = {$urandom, $urandom};
      r = 8'($urandom);
      apply("R6 random", d, r);
    end

    // R8 reset after activity
    apply("R8 pre", fill(8'h10), '0);
    @(negedge clk); rst = 1'b1; in_valid = 1'b1;
    @(posedge clk); #1;
    check("R8 mid reset sum", int'($signed(corr_sum)), 0);
    check("R8 mid reset valid", int'(out_valid), 0);
    @(negedge clk); rst = 1'b0;
    idle();
    @(posedge clk); #1;

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule